// File: doc/BRIEF.md
# Memory-Mapped Data Memory with Framebuffer and Keyboard Word

This block is the data memory of a 16-bit word-addressed processor. One 15-bit CPU address is decoded into three regions: general-purpose storage in the lower half of the space, a one-bit-per-pixel bitmap framebuffer above it, and one keyboard word above the framebuffer. All accesses move whole 16-bit words. Changing a single pixel therefore takes a read, a bit mask and a write by the CPU.

The display is 256 rows of 512 pixels. Each row takes 32 consecutive words, and pixel column `c` of a row is bit `c mod 16` of word `c / 16` in that row. A display scanner reads the framebuffer through a separate read-only port. It presents a row number and a word column, and it receives the word one clock later, without disturbing the CPU port. The keyboard word is loaded on every clock from an external key-code input, which is 0 when no key is down. The CPU can read the keyboard word but cannot write it.

The CPU port and the scanner port are plain control pins with no handshake. The CPU port has no back-pressure and is always ready: a read returns in the same cycle, and a write commits at the next rising edge. The scanner port is also always ready. It accepts a new row and column on every cycle and returns the result one cycle later.

Top module: `memmap_data_mem`

## Requirements
- R1: For addresses 0x0000 to 0x3FFF, a write with `cpu_we` high stores `cpu_wdata` at the rising edge. A read returns the stored word combinationally in the same cycle. Only the low `RAM_AW` address bits (default 12) select a word, so the region aliases every 2^`RAM_AW` words.
- R2: While `cpu_we` is low, the value on `cpu_wdata` changes no stored word.
- R3: Addresses 0x4000 to 0x5FFF are 8192 framebuffer words with the same write-at-edge and combinational-read behaviour as R1.
- R4: The scanner port returns, one clock after `disp_row` and `disp_col` are sampled, the framebuffer word at CPU address 0x4000 + 32*row + col. Pixel (r, c) is bit c mod 16 of word column c/16 of row r.
- R5: A CPU read of 0x6000 returns the `key_code` value sampled at the most recent rising edge.
- R6: A CPU write to 0x6000 has no effect. Reads there still follow `key_code`.
- R7: Addresses 0x6001 to 0x7FFF read as 0. Writes to them change no storage and no framebuffer word.
- R8: Changing the scanner inputs never changes `cpu_rdata`.
- R9: While `rst_n` is low, `disp_word` is 0 and the keyboard word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the keyboard word and the scanner output |
| cpu_addr | input | 15 | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_we | input | 1 | CPU write enable, sampled at the rising edge |
| cpu_rdata | output | 16 | CPU read data, combinational from `cpu_addr` |
| key_code | input | 16 | Character code of the pressed key, 0 when none |
| disp_row | input | 8 | Scanner pixel row |
| disp_col | input | 5 | Scanner word column within the row |
| disp_word | output | 16 | Framebuffer word for the scanner, one cycle latency |

## Verification
CPU reads have no latency. The bench drives each address shortly after a falling edge and samples `cpu_rdata` before the next rising edge. A write first shows up on the read that follows in the next cycle. The keyboard word and the scanner output each sit behind one register. For those, the bench changes `key_code`, `disp_row` or `disp_col` at a falling edge and compares only after the rising edge that follows. It also compares once before that edge where the old value must still be seen. Ignored writes are checked by reading back the words they could have touched, in the cycles after the write.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ADDR_W  = 15;
  localparam int unsigned ROW_W   = 8;
  localparam int unsigned WCOL_W  = 5;
  localparam int unsigned FB_AW   = ROW_W + WCOL_W;
  localparam logic [ADDR_W-1:0] FB_BASE  = 15'h4000;
  localparam logic [ADDR_W-1:0] KEY_ADDR = 15'h6000;

  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_FB   = 2'd1,
    RGN_KEY  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/mm_addr_decode.sv
module mm_addr_decode
  import memmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  always_comb begin
    if (!addr[ADDR_W-1])
      region = RGN_RAM;
    else if (!addr[ADDR_W-2])
      region = RGN_FB;
    else if (addr == KEY_ADDR)
      region = RGN_KEY;
    else
      region = RGN_NONE;
  end
endmodule

// File: rtl/mm_word_store.sv
module mm_word_store #(
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 16,
  parameter bit          SYNC_B = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];

  generate
    if (SYNC_B) begin : g_port_b
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_b <= '0;
        else        rdata_b <= mem[raddr_b];
      end
    end else begin : g_no_port_b
      logic unused_b;
      assign unused_b = ^{raddr_b, rst_n};
      assign rdata_b  = '0;
    end
  endgenerate
endmodule

// File: rtl/mm_key_reg.sv
module mm_key_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] code_in,
  output logic [DW-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_in;
  end
endmodule

// File: rtl/memmap_data_mem.sv
module memmap_data_mem
  import memmap_pkg::*;
#(
  parameter int unsigned RAM_AW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [WORD_W-1:0]    cpu_wdata,
  input  logic                 cpu_we,
  output logic [WORD_W-1:0]    cpu_rdata,
  input  logic [WORD_W-1:0]    key_code,
  input  logic [ROW_W-1:0]     disp_row,
  input  logic [WCOL_W-1:0]    disp_col,
  output logic [WORD_W-1:0]    disp_word
);
  region_e             region;
  logic [WORD_W-1:0]   ram_rd, fb_rd, key_q, ram_unused_b;
  logic [RAM_AW-1:0]   ram_idx;
  logic [FB_AW-1:0]    fb_idx, scan_idx;
  logic                ram_we, fb_we;

  mm_addr_decode u_dec (
    .addr   (cpu_addr),
    .region (region)
  );

  assign ram_idx  = cpu_addr[RAM_AW-1:0];
  assign fb_idx   = cpu_addr[FB_AW-1:0];
  // row-major: 32 words per row, so row forms the upper index bits
  assign scan_idx = {disp_row, disp_col};
  assign ram_we   = cpu_we && (region == RGN_RAM);
  assign fb_we    = cpu_we && (region == RGN_FB);

  mm_word_store #(.AW(RAM_AW), .DW(WORD_W), .SYNC_B(1'b0)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ram_we),
    .waddr   (ram_idx),
    .wdata   (cpu_wdata),
    .raddr_a (ram_idx),
    .rdata_a (ram_rd),
    .raddr_b ('0),
    .rdata_b (ram_unused_b)
  );

  mm_word_store #(.AW(FB_AW), .DW(WORD_W), .SYNC_B(1'b1)) u_fb (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (fb_we),
    .waddr   (fb_idx),
    .wdata   (cpu_wdata),
    .raddr_a (fb_idx),
    .rdata_a (fb_rd),
    .raddr_b (scan_idx),
    .rdata_b (disp_word)
  );

  mm_key_reg #(.DW(WORD_W)) u_key (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_in (key_code),
    .code_q  (key_q)
  );

  always_comb begin
    unique case (region)
      RGN_RAM: cpu_rdata = ram_rd;
      RGN_FB:  cpu_rdata = fb_rd;
      RGN_KEY: cpu_rdata = key_q;
      default: cpu_rdata = '0;
    endcase
  end

  logic unused_top;
  assign unused_top = ^ram_unused_b;
endmodule

// File: rtl/memmap_data_mem_chk.sv
module memmap_data_mem_chk
  import memmap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [WORD_W-1:0] cpu_wdata,
  input logic              cpu_we,
  input logic [WORD_W-1:0] cpu_rdata,
  input logic [WORD_W-1:0] key_code,
  input logic [ROW_W-1:0]  disp_row,
  input logic [WCOL_W-1:0] disp_col,
  input logic [WORD_W-1:0] disp_word
);
  p_ram_write_visible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !cpu_addr[14]) ##1 (cpu_addr == $past(cpu_addr))
      |-> cpu_rdata == $past(cpu_wdata));

  p_fb_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[14:13] == 2'b10) ##1 (cpu_addr == $past(cpu_addr))
      |-> cpu_rdata == $past(cpu_wdata));

  p_key_follows_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == KEY_ADDR) && $past(rst_n) |-> cpu_rdata == $past(key_code));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr > KEY_ADDR) |-> cpu_rdata == '0);

  p_scan_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we && cpu_addr != KEY_ADDR) ##1 ($stable(cpu_addr) && cpu_addr != KEY_ADDR)
      |-> $stable(cpu_rdata));

  p_disp_reset_r9: assert property (@(posedge clk)
    !rst_n |-> disp_word == '0);

  logic unused_chk;
  assign unused_chk = ^{disp_row, disp_col};
endmodule

bind memmap_data_mem memmap_data_mem_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_we    (cpu_we),
  .cpu_rdata (cpu_rdata),
  .key_code  (key_code),
  .disp_row  (disp_row),
  .disp_col  (disp_col),
  .disp_word (disp_word)
);

// File: tb/memmap_data_mem_test.sv
module memmap_data_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_rdata;
  logic [15:0] key_code = '0;
  logic [7:0]  disp_row = '0;
  logic [4:0]  disp_col = '0;
  logic [15:0] disp_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  memmap_data_mem uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .key_code(key_code),
    .disp_row(disp_row), .disp_col(disp_col), .disp_word(disp_word)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at falling edge, settle 2 ns (still before the rising edge)
  task automatic cpu_cycle(input logic we, input logic [14:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #2;
  endtask

  // {we, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 15'h0000, 16'h1234, 16'h0000},  // R1 write low edge
    {1'b1, 15'h0005, 16'hBEEF, 16'h0000},  // R1
    {1'b1, 15'h0001, 16'h1111, 16'h0000},  // R1
    {1'b1, 15'h3FFF, 16'h0F0F, 16'h0000},  // R1 top of region
    {1'b1, 15'h4000, 16'hFFFF, 16'h0000},  // R3 first framebuffer word
    {1'b1, 15'h4001, 16'h2222, 16'h0000},  // R3
    {1'b1, 15'h5FFF, 16'h8001, 16'h0000},  // R3 last framebuffer word
    {1'b0, 15'h0000, 16'hDEAD, 16'h1234},  // R1 read, R2 stray data
    {1'b0, 15'h0005, 16'hDEAD, 16'hBEEF},  // R2
    {1'b0, 15'h0005, 16'h0000, 16'hBEEF},  // R2 still unchanged
    {1'b0, 15'h0FFF, 16'h0000, 16'h0F0F},  // R1 alias of 0x3FFF
    {1'b0, 15'h4000, 16'h0000, 16'hFFFF},  // R3
    {1'b0, 15'h5FFF, 16'h0000, 16'h8001},  // R3
    {1'b1, 15'h6001, 16'h5555, 16'h0000},  // R7 write to hole
    {1'b1, 15'h7FFF, 16'h7777, 16'h0000},  // R7
    {1'b0, 15'h6001, 16'h0000, 16'h0000},  // R7 reads zero
    {1'b0, 15'h7FFF, 16'h0000, 16'h0000},  // R7
    {1'b0, 15'h0001, 16'h0000, 16'h1111},  // R7 storage untouched
    {1'b0, 15'h4001, 16'h0000, 16'h2222},  // R7 framebuffer untouched
    {1'b0, 15'h1FFF, 16'h0000, 16'h0F0F}   // R7 alias of 0x7FFF low bits untouched
  };

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    // R9: reset state
    key_code = 16'h0041;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cpu_addr = 15'h6000; #2;
    check("R9 key word in reset", cpu_rdata, 16'h0000);
    check("R9 disp_word in reset", disp_word, 16'h0000);
    rst_n = 1'b1;
    key_code = 16'h0000;
    @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      cpu_cycle(VEC[i][47], VEC[i][46:32], VEC[i][31:16]);
      if (!VEC[i][47]) check("R1/R2/R3/R7 vector", cpu_rdata, VEC[i][15:0]);
    end

    // R5: keyboard latency of one edge
    cpu_cycle(1'b0, 15'h6000, 16'h0000);
    key_code = 16'd65;
    #1 check("R5 before edge", cpu_rdata, 16'h0000);
    cpu_cycle(1'b0, 15'h6000, 16'h0000);
    check("R5 key A", cpu_rdata, 16'd65);
    // R6: write to keyboard ignored
    cpu_cycle(1'b1, 15'h6000, 16'hAAAA);
    cpu_cycle(1'b0, 15'h6000, 16'h0000);
    check("R6 write ignored", cpu_rdata, 16'd65);
    key_code = 16'h0000;
    cpu_cycle(1'b0, 15'h6000, 16'h0000);
    check("R5 key released", cpu_rdata, 16'h0000);

    // R4: set pixel (row 3, col 37) by read-modify-write; word 0x4062 bit 5
    cpu_cycle(1'b1, 15'h4062, 16'h0000);
    cpu_cycle(1'b0, 15'h4062, 16'h0000);
    w = cpu_rdata | (16'h1 << (37 % 16));
    cpu_cycle(1'b1, 15'h4062, w);
    cpu_cycle(1'b0, 15'h0005, 16'h0000);
    disp_row = 8'd3; disp_col = 5'd2;
    #1 check("R8 cpu read during scan change", cpu_rdata, 16'hBEEF);
    @(negedge clk); #2;
    check("R4 pixel word", disp_word, 16'h0020);
    check("R8 cpu read after scan", cpu_rdata, 16'hBEEF);
    disp_row = 8'd255; disp_col = 5'd31;
    @(negedge clk); #2;
    check("R4 last word", disp_word, 16'h8001);
    disp_row = 8'd0; disp_col = 5'd0;
    #1 check("R4 latency hold", disp_word, 16'h8001);
    @(negedge clk); #2;
    check("R4 first word", disp_word, 16'hFFFF);

    // R9: reset clears scanner output
    rst_n = 1'b0; #1;
    check("R9 disp_word reset", disp_word, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule